// File: doc/BRIEF.md
# Programmable Chip-Select Access Timer

This block runs one external memory-bus access for a single chip-select area. An internal master raises a request with an address, a write flag, byte enables and write data. When the area bits of the address match the programmed area code, the block runs one bus cycle and then pulses an acknowledge. The bus cycle drives the chip select, the read strobe (also usable as output enable), the per-byte write strobes, a bus-start pulse, the address and the write data.

The cycle has five timed phases, in this order: address setup, strobe assert delay, strobe (with wait states), strobe negate delay and address hold. Each phase length comes from a configuration word written through a simple write port. The timing fields are copied when an access starts, so a configuration write during an access only affects later accesses. An external ready input passes through a two-flop synchronizer. It can lengthen the strobe phase, but only when the programmed wait count is nonzero.

Top module: `cs_timing_ctrl`

## Requirements
- R1: An access starts only when `req` is high and `req_addr[28:26]` equals the configured area code, which is 3'b101 after reset. A request for any other area causes no bus activity and no `ack`.
- R2: Before chip select goes low, the address is driven with `bus_cs_n` high for exactly the setup count of cycles (0 to 7).
- R3: After chip select goes low, the strobe stays high for the assert-delay count of cycles. For reads this is the read delay field and for writes the write delay field (each 0 to 7).
- R4: When ready is high, the strobe is low for 1 + W cycles. W is the wait field limited to 25, so a field value of 26 to 31 acts as 25.
- R5: When W is 0, `ext_rdy` is ignored. When W is nonzero, the strobe continues past its programmed length until the synchronized ready is high. If `ext_rdy` rises during strobe cycle k (counting from 0), the strobe lasts max(W, k+2) + 1 cycles.
- R6: After the strobe ends, chip select stays low for the negate-delay count of cycles (0 to 7).
- R7: After chip select goes high, the address stays driven for the hold count of cycles (0 to 7).
- R8: `bus_bs_n` is low in the first chip-select-low cycle. It is low for the first two such cycles only when the long-start flag is set and the assert delay used for this access is nonzero.
- R9: During the strobe of a read, `bus_rd_n` is low and all `bus_we_n` bits are high. During the strobe of a write, `bus_we_n[i]` is low exactly where `req_be[i]` is 1, `bus_rd_n` is high, and `bus_wdata` carries the write data.
- R10: `ack` is high for exactly one cycle, in the cycle after the last bus cycle. In that cycle every strobe is high and `bus_addr` is 0.
- R11: For a read, `rd_data` holds the value of `bus_rdata` sampled on the last strobe cycle.
- R12: After reset, all strobes are high, `ack` is low and `bus_addr` is 0.
- R13: A write with `cfg_wr` loads `cfg_wdata`. The fields are: [2:0] setup, [5:3] read assert delay, [8:6] write assert delay, [13:9] wait, [16:14] negate delay, [19:17] hold, [20] long-start flag, [23:21] area code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Load the configuration word |
| cfg_wdata | input | 24 | Configuration word |
| req | input | 1 | Access request from the master |
| req_addr | input | ADDR_W | Access address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_be | input | DATA_W/8 | Byte enables |
| req_wdata | input | DATA_W | Write data |
| ack | output | 1 | One-cycle completion pulse |
| rd_data | output | DATA_W | Captured read data |
| bus_addr | output | ADDR_W | External address |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_rd_n | output | 1 | Read strobe / output enable, active low |
| bus_we_n | output | DATA_W/8 | Byte write strobes, active low |
| bus_bs_n | output | 1 | Bus-start pulse, active low |
| bus_wdata | output | DATA_W | External write data |
| bus_rdata | input | DATA_W | External read data |
| ext_rdy | input | 1 | External ready, asynchronous, high = ready |

## Verification
The access sequence is run with random settings of all five phase lengths, random reads and writes, random byte enables and random area codes. This shows that each phase counter is loaded from its own field and that zero-length phases are skipped. Directed cases cover the following:
- A wait field above the limit, to expose a missing clamp.
- Ready held low with a zero wait count, to show that ready is ignored.
- Ready released late with a nonzero wait count, to fix the synchronizer latency.
- The long-start flag with zero and nonzero assert delays, to separate the read and write delay choice.
- A request to a foreign area, followed by moving the area code to that area.

// File: rtl/cs_timing_pkg.sv
`timescale 1ns/1ps
package cs_timing_pkg;

  localparam int WAIT_CAP = 25;
  localparam int AREA_W   = 3;

  typedef enum logic [2:0] {
    PH_IDLE, PH_SETUP, PH_ASSERT, PH_STROBE, PH_NEGATE, PH_HOLD, PH_DONE
  } phase_e;

  // packed so that setup sits at [2:0] and area at [23:21]
  typedef struct packed {
    logic [AREA_W-1:0] area;
    logic              bs2;
    logic [2:0]        hold;
    logic [2:0]        neg;
    logic [4:0]        waits;
    logic [2:0]        wr_dly;
    logic [2:0]        rd_dly;
    logic [2:0]        setup;
  } timing_t;

  localparam int CFG_W = $bits(timing_t);

  function automatic timing_t unpack_cfg(logic [CFG_W-1:0] w);
    timing_t t;
    t = timing_t'(w);
    if (t.waits > 5'(WAIT_CAP)) t.waits = 5'(WAIT_CAP);
    return t;
  endfunction

  function automatic logic [2:0] assert_dly(timing_t t, logic wr);
    return wr ? t.wr_dly : t.rd_dly;
  endfunction

  function automatic logic [4:0] phase_len(phase_e ph, timing_t t, logic wr);
    case (ph)
      PH_SETUP:  return {2'b00, t.setup};
      PH_ASSERT: return {2'b00, assert_dly(t, wr)};
      PH_STROBE: return t.waits + 5'd1;
      PH_NEGATE: return {2'b00, t.neg};
      PH_HOLD:   return {2'b00, t.hold};
      default:   return 5'd1;
    endcase
  endfunction

  // first phase after ph whose length is nonzero (DONE when none)
  function automatic phase_e next_phase(phase_e ph, timing_t t, logic wr);
    phase_e nx;
    nx = PH_DONE;
    for (int k = int'(PH_HOLD); k > int'(ph); k--) begin
      if (phase_len(phase_e'(3'(k)), t, wr) != 5'd0) nx = phase_e'(3'(k));
    end
    return nx;
  endfunction

  function automatic logic [1:0] bs_cycles(timing_t t, logic wr);
    return (t.bs2 && assert_dly(t, wr) != 3'd0) ? 2'd2 : 2'd1;
  endfunction

endpackage

// File: rtl/cs_rdy_sync.sv
`timescale 1ns/1ps
module cs_rdy_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-2:0], d};
  end

  assign q = sh[STAGES-1];
endmodule

// File: rtl/cs_seq.sv
`timescale 1ns/1ps
module cs_seq
  import cs_timing_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    start,
  input  timing_t t_live,
  input  logic    wr_live,
  input  logic    rdy_s,
  output phase_e  ph,
  output timing_t t_s,
  output logic    wr_s,
  output logic    stretch,
  output logic    last_strobe
);
  logic [4:0] cnt;
  timing_t    t_sel;
  logic       w_sel;
  phase_e     nx;
  logic [4:0] nlen;

  always_comb begin
    t_sel = (ph == PH_IDLE) ? t_live : t_s;
    w_sel = (ph == PH_IDLE) ? wr_live : wr_s;
    nx    = next_phase(ph, t_sel, w_sel);
    nlen  = phase_len(nx, t_sel, w_sel);
  end

  assign stretch     = (ph == PH_STROBE) && (cnt == 5'd0) && (t_s.waits != 5'd0) && !rdy_s;
  assign last_strobe = (ph == PH_STROBE) && (cnt == 5'd0) && !stretch;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph   <= PH_IDLE;
      cnt  <= '0;
      t_s  <= '0;
      wr_s <= 1'b0;
    end else begin
      case (ph)
        PH_IDLE: if (start) begin
          t_s  <= t_live;
          wr_s <= wr_live;
          ph   <= nx;
          cnt  <= nlen - 5'd1;
        end
        PH_DONE: ph <= PH_IDLE;
        default: begin
          if (cnt != 5'd0) cnt <= cnt - 5'd1;
          else if (!stretch) begin
            ph  <= nx;
            cnt <= nlen - 5'd1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/cs_pins.sv
`timescale 1ns/1ps
module cs_pins
  import cs_timing_pkg::*;
#(
  parameter int ADDR_W = 29,
  parameter int DATA_W = 32,
  localparam int BYTES = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  phase_e            ph,
  input  logic              wr,
  input  logic [BYTES-1:0]  be,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [1:0]        bs_len,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_cs_n,
  output logic              bus_rd_n,
  output logic [BYTES-1:0]  bus_we_n,
  output logic              bus_bs_n,
  output logic [DATA_W-1:0] bus_wdata
);
  logic       active, cs_low, stb;
  logic [1:0] age;

  assign active = (ph != PH_IDLE) && (ph != PH_DONE);
  assign cs_low = (ph == PH_ASSERT) || (ph == PH_STROBE) || (ph == PH_NEGATE);
  assign stb    = (ph == PH_STROBE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      age <= '0;
    else if (!cs_low) age <= '0;
    else if (age != 2'd2) age <= age + 2'd1;
  end

  assign bus_cs_n  = !cs_low;
  assign bus_bs_n  = !(cs_low && (age < bs_len));
  assign bus_rd_n  = !(stb && !wr);
  assign bus_addr  = active ? addr : '0;
  assign bus_wdata = (active && wr) ? wdata : '0;

  for (genvar i = 0; i < BYTES; i++) begin : g_we
    assign bus_we_n[i] = !(stb && wr && be[i]);
  end
endmodule

// File: rtl/cs_timing_ctrl.sv
`timescale 1ns/1ps
module cs_timing_ctrl
  import cs_timing_pkg::*;
#(
  parameter int ADDR_W   = 29,
  parameter int DATA_W   = 32,
  parameter int AREA_LSB = 26,
  localparam int BYTES   = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              req,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic [BYTES-1:0]  req_be,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              ack,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_cs_n,
  output logic              bus_rd_n,
  output logic [BYTES-1:0]  bus_we_n,
  output logic              bus_bs_n,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              ext_rdy
);
  localparam logic [CFG_W-1:0] CFG_RST = {3'b101, {(CFG_W-AREA_W){1'b0}}};

  logic [CFG_W-1:0]  cfg_q;
  timing_t           t_live, t_s;
  logic              hit, start, rdy_s, wr_s, stretch, last_strobe;
  phase_e            ph;
  logic [ADDR_W-1:0] a_q;
  logic [BYTES-1:0]  be_q;
  logic [DATA_W-1:0] wd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= CFG_RST;
    else if (cfg_wr) cfg_q <= cfg_wdata;
  end

  assign t_live = unpack_cfg(cfg_q);
  assign hit    = req && (req_addr[AREA_LSB +: AREA_W] == t_live.area);
  assign start  = hit && (ph == PH_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q  <= '0;
      be_q <= '0;
      wd_q <= '0;
    end else if (start) begin
      a_q  <= req_addr;
      be_q <= req_be;
      wd_q <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    rd_data <= '0;
    else if (last_strobe && !wr_s) rd_data <= bus_rdata;
  end

  assign ack = (ph == PH_DONE);

  cs_rdy_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(ext_rdy), .q(rdy_s)
  );

  cs_seq u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .t_live(t_live),
    .wr_live(req_write), .rdy_s(rdy_s), .ph(ph), .t_s(t_s), .wr_s(wr_s),
    .stretch(stretch), .last_strobe(last_strobe)
  );

  cs_pins #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
    .clk(clk), .rst_n(rst_n), .ph(ph), .wr(wr_s), .be(be_q), .addr(a_q),
    .wdata(wd_q), .bs_len(bs_cycles(t_s, wr_s)), .bus_addr(bus_addr),
    .bus_cs_n(bus_cs_n), .bus_rd_n(bus_rd_n), .bus_we_n(bus_we_n),
    .bus_bs_n(bus_bs_n), .bus_wdata(bus_wdata)
  );
endmodule

// File: rtl/cs_timing_chk.sv
`timescale 1ns/1ps
module cs_timing_chk #(
  parameter int BYTES = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ack,
  input logic             cs_n,
  input logic             rd_n,
  input logic [BYTES-1:0] we_n,
  input logic             bs_n,
  input logic             stretch,
  input logic             last_strobe,
  input logic [4:0]       wait_s
);
  // R10
  ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) ack |=> !ack);
  // R10
  ack_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> (cs_n && rd_n && (&we_n) && bs_n));
  // R9
  rd_in_cs_chk: assert property (@(posedge clk) disable iff (!rst_n) !rd_n |-> !cs_n);
  // R9
  we_in_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(&we_n) |-> (!cs_n && rd_n));
  // R8
  bs_in_cs_chk: assert property (@(posedge clk) disable iff (!rst_n) !bs_n |-> !cs_n);
  // R5
  stretch_needs_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stretch |-> (wait_s != 5'd0));
  // R4
  wait_cap_chk: assert property (@(posedge clk) disable iff (!rst_n) wait_s <= 5'd25);
  // R11
  strobe_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_strobe |=> (rd_n && (&we_n)));
endmodule

bind cs_timing_ctrl cs_timing_chk #(.BYTES(BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .ack(ack), .cs_n(bus_cs_n), .rd_n(bus_rd_n),
  .we_n(bus_we_n), .bs_n(bus_bs_n), .stretch(stretch),
  .last_strobe(last_strobe), .wait_s(t_s.waits)
);

// File: tb/cs_timing_ctrl_tb.sv
`timescale 1ns/1ps
module cs_timing_ctrl_tb;
  logic        clk = 0, rst_n = 0, cfg_wr = 0, req = 0, req_write = 0, ext_rdy = 1;
  logic [23:0] cfg_wdata = '0;
  logic [28:0] req_addr = '0;
  logic [3:0]  req_be = '0;
  logic [31:0] req_wdata = '0, bus_rdata = '0;
  logic        ack, bus_cs_n, bus_rd_n, bus_bs_n;
  logic [31:0] rd_data, bus_wdata;
  logic [28:0] bus_addr;
  logic [3:0]  bus_we_n;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  bit [2:0] c_set, c_rd, c_wr, c_neg, c_hld, c_area;
  bit [4:0] c_wait;
  bit       c_bs2;

  always #10 clk = ~clk;

  cs_timing_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .req(req),
    .req_addr(req_addr), .req_write(req_write), .req_be(req_be), .req_wdata(req_wdata),
    .ack(ack), .rd_data(rd_data), .bus_addr(bus_addr), .bus_cs_n(bus_cs_n),
    .bus_rd_n(bus_rd_n), .bus_we_n(bus_we_n), .bus_bs_n(bus_bs_n),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_rdy(ext_rdy)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int eff_wait(bit [4:0] w);
    return (w > 25) ? 25 : int'(w);
  endfunction

  function automatic int exp_strobe(bit [4:0] w, int rel_k);
    int ew = eff_wait(w);
    if (ew == 0) return 1;
    if (rel_k >= 0) return ((ew > rel_k + 2) ? ew : rel_k + 2) + 1;
    return ew + 1;
  endfunction

  function automatic int exp_bs(bit bs2, bit [2:0] d);
    return (bs2 && d != 0) ? 2 : 1;
  endfunction

  // called at a negedge, returns at a negedge (R13 field layout)
  task automatic set_cfg();
    cfg_wdata = {c_area, c_bs2, c_hld, c_neg, c_wait, c_wr, c_rd, c_set};
    cfg_wr = 1;
    @(negedge clk);
    cfg_wr = 0;
  endtask

  task automatic access(input bit [25:0] low, input bit w, input bit [3:0] be,
                        input bit [31:0] wd, input bit [31:0] rdv, input int rel_k);
    int nset = 0, nasr = 0, nstb = 0, nneg = 0, nhld = 0, nbs = 0, stage = 0, cyc = 0;
    bit addr_ok = 1, pat_ok = 1, got_ack = 0;
    bit [28:0] a = {c_area, low};
    bit [2:0] d = w ? c_wr : c_rd;
    req = 1; req_addr = a; req_write = w; req_be = be; req_wdata = wd; bus_rdata = rdv;
    forever begin
      @(negedge clk);
      cyc++;
      if (cyc > 300) break;
      if (ack) begin
        got_ack = 1;
        chk(bus_cs_n && bus_rd_n && (&bus_we_n) && bus_bs_n && bus_addr == 0,
            "R10 idle at ack", {bus_cs_n, bus_rd_n, bus_bs_n}, 7);
        req = 0;
        break;
      end
      if (bus_addr != a) addr_ok = 0;
      if (!bus_bs_n) nbs++;
      if (!bus_rd_n || !(&bus_we_n)) begin
        if (rel_k >= 0 && nstb == rel_k) ext_rdy = 1;
        stage = 2; nstb++;
        if (w) begin
          if (!(bus_rd_n && bus_we_n == ~be && bus_wdata == wd)) pat_ok = 0;
        end else if (!(!bus_rd_n && (&bus_we_n))) pat_ok = 0;
      end else if (!bus_cs_n) begin
        if (stage < 2) nasr++; else nneg++;
      end else begin
        if (stage < 2) nset++; else nhld++;
      end
    end
    chk(got_ack, "R10 ack seen", got_ack, 1);
    chk(addr_ok, "R2 R7 address driven", addr_ok, 1);
    chk(nset == c_set, "R2 setup cycles", nset, c_set);
    chk(nasr == d, "R3 assert delay", nasr, d);
    chk(nstb == exp_strobe(c_wait, rel_k), "R4 R5 strobe cycles", nstb, exp_strobe(c_wait, rel_k));
    chk(nneg == c_neg, "R6 negate delay", nneg, c_neg);
    chk(nhld == c_hld, "R7 hold cycles", nhld, c_hld);
    chk(nbs == exp_bs(c_bs2, d), "R8 start pulse", nbs, exp_bs(c_bs2, d));
    chk(pat_ok, "R9 strobe pattern", pat_ok, 1);
    if (!w) chk(rd_data == rdv, "R11 read capture", rd_data, rdv);
    @(negedge clk);
    chk(!ack, "R10 ack single", ack, 0);
  endtask

  task automatic rand_cfg();
    c_set = 3'($urandom_range(0, 7)); c_rd = 3'($urandom_range(0, 7));
    c_wr = 3'($urandom_range(0, 7)); c_neg = 3'($urandom_range(0, 7));
    c_hld = 3'($urandom_range(0, 7)); c_wait = 5'($urandom_range(0, 31));
    c_bs2 = 1'($urandom_range(0, 1)); c_area = 3'($urandom_range(0, 7));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL R10 watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    c_set = 0; c_rd = 0; c_wr = 0; c_neg = 0; c_hld = 0; c_wait = 0; c_bs2 = 0; c_area = 3'b101;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R12 reset state
    chk(bus_cs_n && bus_rd_n && (&bus_we_n) && bus_bs_n && !ack && bus_addr == 0,
        "R12 reset idle", {bus_cs_n, bus_rd_n, bus_bs_n, ack}, 4'b1110);
    // R1 reset area code 101 with no config write
    access(26'h12345, 0, 4'hF, 32'h0, 32'hCAFE0001, -1);
    // R4 wait clamp: field 30 acts as 25
    c_wait = 5'd30; c_set = 1; c_rd = 2; c_neg = 1; c_hld = 2; set_cfg();
    access(26'h00100, 0, 4'hF, 32'h0, 32'hA5A5A5A5, -1);
    // R5 late ready with wait 3, released in strobe cycle 6
    c_wait = 5'd3; set_cfg();
    ext_rdy = 0; repeat (3) @(negedge clk);
    access(26'h00200, 1, 4'b0101, 32'h11223344, 32'h0, 6);
    repeat (3) @(negedge clk);
    // R5 ready ignored with zero wait
    c_wait = 5'd0; set_cfg();
    ext_rdy = 0; repeat (3) @(negedge clk);
    access(26'h00300, 0, 4'hF, 32'h0, 32'h5555AAAA, -1);
    ext_rdy = 1; repeat (3) @(negedge clk);
    // R8 long start: read delay 0 gives 1, write delay 4 gives 2
    c_bs2 = 1; c_rd = 0; c_wr = 4; set_cfg();
    access(26'h00400, 0, 4'hF, 32'h0, 32'h00C0FFEE, -1);
    access(26'h00404, 1, 4'b1000, 32'hDEADBEEF, 32'h0, -1);
    // R1 foreign area is ignored
    req = 1; req_addr = {3'b010, 26'h5}; req_write = 0; req_be = 4'hF;
    begin
      bit quiet = 1;
      for (int i = 0; i < 15; i++) begin
        @(negedge clk);
        if (!bus_cs_n || ack || bus_addr != 0) quiet = 0;
      end
      chk(quiet, "R1 foreign area ignored", quiet, 1);
    end
    req = 0; @(negedge clk);
    // R13 R1 move the area code to 010
    c_area = 3'b010; set_cfg();
    access(26'h5, 0, 4'hF, 32'h0, 32'h01020304, -1);
    // random mix
    for (int n = 0; n < 40; n++) begin
      rand_cfg(); set_cfg();
      access(26'($urandom), 1'($urandom_range(0, 1)), 4'($urandom_range(1, 15)),
             $urandom, $urandom, -1);
    end
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule